// File: doc/BRIEF.md
# Programmable I/O Chip-Select Decoder

This block sits in a bridge toward a slow utility bus and decides, for each I/O cycle, which legacy peripheral is addressed. It carries a 16-bit I/O address, a read and a write strobe and a valid flag. From these it produces a 3-bit encoded select code, a transceiver output-enable, a latch strobe and a chip-select for the real-time clock, and two strobes for an external configuration RAM: a page select and a memory select.

Two small configuration registers hold the decode setup: per-device enable bits and 2-bit range-select fields for two serial ports and one parallel port. Software programs them through a simple write port with an offset and reads them back through a combinational read port. Every output is combinational from the stored configuration and the present cycle inputs. A register write takes effect at the next rising clock edge.

Register at offset 0 (control): bit 0 enables the clock range, bit 1 enables the keyboard range, and bits 7:2 are stored only. Register at offset 1 (port select): bits 1:0 choose the serial A range, bits 3:2 the serial B range, bits 5:4 the parallel range, bit 6 enables port 92h, and bit 7 enables the configuration RAM. The select codes are: none 0, keyboard 1, clock 2, serial A 3, serial B 4, parallel 5, configuration RAM 6, port 92h 7.

Top module: `iocs_decoder`

## Requirements
- R1: After reset the control register reads 8'h03, the port-select register reads 8'h4C (serial A 00, serial B 11, parallel 00, port 92h on, configuration RAM off), and offsets 2 and 3 read 8'h00.
- R2: A register write changes the read-back value only after the next rising clock edge. Reads return the full stored byte, including the reserved serial encoding 10. Writes to offsets 2 and 3 are ignored, and those offsets read zero.
- R3: A cycle counts as active only when io_valid is high and exactly one of io_rd and io_wr is high. Otherwise cs_code is 0 and every strobe and xcvr_oe are low.
- R4: With the keyboard enable set, an active cycle to 0060h, 0062h, 0064h or 0066h gives code 1. With parameter KBD_ALL_PORTS=0, only 0060h and 0064h decode. With the enable clear, none of these addresses decodes, and odd addresses in the group never decode.
- R5: With the clock enable set, an active cycle to 0070h–0077h gives code 2 and raises both rtc_ale and rtc_cs. With the enable clear, code and both strobes stay low. At most one of rtc_cs, cfg_page_cs and cfg_mem_cs is high.
- R6: The serial A field (port-select bits 1:0) maps 00 to 03F8h–03FFh and 01 to 02F8h–02FFh, both with code 3. The values 10 (reserved) and 11 (off) decode nothing.
- R7: The serial B field (port-select bits 3:2) uses the same mapping with code 4. When it equals the serial A field, serial B is suppressed. When several devices match, the largest code wins.
- R8: The parallel field (port-select bits 5:4) maps 00 to 03BCh–03BFh, 01 to 0378h–037Fh and 10 to 0278h–027Fh, all with code 5. The value 11 disables the port.
- R9: With the configuration RAM enable (port-select bit 7) set, a write to 0C00h gives code 6 and cfg_page_cs. A read of 0C00h decodes nothing.
- R10: With the configuration RAM enable set, reads and writes to 0800h–08FFh give code 6 and cfg_mem_cs. With the bit clear, neither configuration strobe appears and the code stays 0.
- R11: With port-select bit 6 set, an active cycle to 0092h gives code 7. With the bit clear, 0092h decodes nothing.
- R12: xcvr_oe is high exactly when cs_code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the register at cfg_addr |
| io_valid | input | 1 | I/O cycle valid |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| cs_code | output | 3 | Encoded device select, 0 when nothing matches |
| xcvr_oe | output | 1 | Utility-bus transceiver enable |
| rtc_ale | output | 1 | Clock address-latch strobe |
| rtc_cs | output | 1 | Clock chip-select |
| cfg_page_cs | output | 1 | Configuration page select (writes to 0C00h) |
| cfg_mem_cs | output | 1 | Configuration memory select (0800h–08FFh) |

## Verification
The only state is the two configuration registers. A wrong bit there shows up at the ports in the same cycle that an address from the affected range is presented. The same wrong bit appears at once on cfg_rdata when that offset is selected. A corrupted field therefore appears either as a missing or extra select code on the next matching cycle, or as a read-back mismatch one edge after the write. Suppression of serial B is visible only because the larger code wins: if the equal-field check were lost, code 4 would replace code 3 on the shared range.

// File: rtl/iocs_pkg.sv
package iocs_pkg;

    localparam int CODE_W = 3;
    localparam int NDEV   = 1 << CODE_W;

    localparam int DEV_NONE = 0;
    localparam int DEV_KBD  = 1;
    localparam int DEV_RTC  = 2;
    localparam int DEV_SERA = 3;
    localparam int DEV_SERB = 4;
    localparam int DEV_PAR  = 5;
    localparam int DEV_CFG  = 6;
    localparam int DEV_P92  = 7;

    localparam int REG_CTL = 0;
    localparam int REG_SEL = 1;
    localparam int NREG    = 2;

    localparam logic [7:0] RST_CTL = 8'h03;
    localparam logic [7:0] RST_SEL = 8'h4C;

    typedef struct packed {
        logic       cfg_en;
        logic       p92_en;
        logic [1:0] par_sel;
        logic [1:0] serb_sel;
        logic [1:0] sera_sel;
        logic       kbd_en;
        logic       rtc_en;
    } iocs_cfg_t;

endpackage

// File: rtl/iocs_cfg_regs.sv
module iocs_cfg_regs
    import iocs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output iocs_cfg_t         cfg
);

    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_V =
            (g == REG_CTL) ? DATA_W'(RST_CTL) : DATA_W'(RST_SEL);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RST_V;
            end else if (we && addr == REG_AW'(g)) begin
                regs_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == REG_AW'(i)) rdata = regs_q[i];
        end
    end

    always_comb begin
        cfg.rtc_en   = regs_q[REG_CTL][0];
        cfg.kbd_en   = regs_q[REG_CTL][1];
        cfg.sera_sel = regs_q[REG_SEL][1:0];
        cfg.serb_sel = regs_q[REG_SEL][3:2];
        cfg.par_sel  = regs_q[REG_SEL][5:4];
        cfg.p92_en   = regs_q[REG_SEL][6];
        cfg.cfg_en   = regs_q[REG_SEL][7];
    end

endmodule

// File: rtl/iocs_range_match.sv
module iocs_range_match #(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] MASK = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    assign hit = (((addr ^ BASE) & MASK) == '0);

endmodule

// File: rtl/iocs_addr_decode.sv
module iocs_addr_decode
    import iocs_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter bit KBD_ALL_PORTS = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              active,
    input  logic              is_wr,
    input  iocs_cfg_t         cfg,
    output logic [NDEV-1:0]   dev_hit,
    output logic              page_hit,
    output logic              mem_hit
);

    localparam logic [ADDR_W-1:0] M8 = ~ADDR_W'(7);
    localparam logic [ADDR_W-1:0] M4 = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] M256 = ~ADDR_W'(255);
    localparam logic [ADDR_W-1:0] MALL = '1;

    logic kbd_m, rtc_m, com1_m, com2_m, lpt1_m, lpt2_m, lpt3_m;
    logic page_m, mem_m, p92_m;

    if (KBD_ALL_PORTS) begin : g_kbd_wide
        iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0060)),
                           .MASK(~ADDR_W'(16'h0006)))
            u_kbd (.addr(addr), .hit(kbd_m));
    end else begin : g_kbd_narrow
        iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0060)),
                           .MASK(~ADDR_W'(16'h0004)))
            u_kbd (.addr(addr), .hit(kbd_m));
    end

    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0070)), .MASK(M8))
        u_rtc  (.addr(addr), .hit(rtc_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h03F8)), .MASK(M8))
        u_com1 (.addr(addr), .hit(com1_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h02F8)), .MASK(M8))
        u_com2 (.addr(addr), .hit(com2_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h03BC)), .MASK(M4))
        u_lpt1 (.addr(addr), .hit(lpt1_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0378)), .MASK(M8))
        u_lpt2 (.addr(addr), .hit(lpt2_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0278)), .MASK(M8))
        u_lpt3 (.addr(addr), .hit(lpt3_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0C00)), .MASK(MALL))
        u_page (.addr(addr), .hit(page_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0800)), .MASK(M256))
        u_mem  (.addr(addr), .hit(mem_m));
    iocs_range_match #(.ADDR_W(ADDR_W), .BASE(ADDR_W'(16'h0092)), .MASK(MALL))
        u_p92  (.addr(addr), .hit(p92_m));

    function automatic logic serial_pick(input logic [1:0] sel,
                                         input logic c1, input logic c2);
        unique case (sel)
            2'b00:   serial_pick = c1;
            2'b01:   serial_pick = c2;
            default: serial_pick = 1'b0;
        endcase
    endfunction

    logic par_m, serb_clash;

    always_comb begin
        unique case (cfg.par_sel)
            2'b00:   par_m = lpt1_m;
            2'b01:   par_m = lpt2_m;
            2'b10:   par_m = lpt3_m;
            default: par_m = 1'b0;
        endcase
    end

    assign serb_clash = (cfg.serb_sel == cfg.sera_sel);

    always_comb begin
        page_hit = active && is_wr && cfg.cfg_en && page_m;
        mem_hit  = active && cfg.cfg_en && mem_m;
        dev_hit  = '0;
        dev_hit[DEV_KBD]  = active && cfg.kbd_en && kbd_m;
        dev_hit[DEV_RTC]  = active && cfg.rtc_en && rtc_m;
        dev_hit[DEV_SERA] = active && serial_pick(cfg.sera_sel, com1_m, com2_m);
        dev_hit[DEV_SERB] = active && !serb_clash
                            && serial_pick(cfg.serb_sel, com1_m, com2_m);
        dev_hit[DEV_PAR]  = active && par_m;
        dev_hit[DEV_CFG]  = page_hit || mem_hit;
        dev_hit[DEV_P92]  = active && cfg.p92_en && p92_m;
    end

endmodule

// File: rtl/iocs_code_enc.sv
module iocs_code_enc
    import iocs_pkg::*;
(
    input  logic [NDEV-1:0]   hit,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        code = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (hit[i]) code = CODE_W'(i);
        end
    end

endmodule

// File: rtl/iocs_decoder.sv
module iocs_decoder
    import iocs_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int REG_AW        = 2,
    parameter int ADDR_W        = 16,
    parameter bit KBD_ALL_PORTS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              io_valid,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic [CODE_W-1:0] cs_code,
    output logic              xcvr_oe,
    output logic              rtc_ale,
    output logic              rtc_cs,
    output logic              cfg_page_cs,
    output logic              cfg_mem_cs
);

    iocs_cfg_t       cfg;
    logic [NDEV-1:0] dev_hit;
    logic            active;
    logic            page_hit, mem_hit;

    assign active = io_valid && (io_rd ^ io_wr);

    iocs_cfg_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    iocs_addr_decode #(.ADDR_W(ADDR_W), .KBD_ALL_PORTS(KBD_ALL_PORTS)) u_dec (
        .addr     (io_addr),
        .active   (active),
        .is_wr    (io_wr),
        .cfg      (cfg),
        .dev_hit  (dev_hit),
        .page_hit (page_hit),
        .mem_hit  (mem_hit)
    );

    iocs_code_enc u_enc (
        .hit  (dev_hit),
        .code (cs_code)
    );

    always_comb begin
        xcvr_oe     = active && (cs_code != '0);
        rtc_ale     = dev_hit[DEV_RTC];
        rtc_cs      = dev_hit[DEV_RTC];
        cfg_page_cs = page_hit;
        cfg_mem_cs  = mem_hit;
    end

endmodule

// File: rtl/iocs_decoder_chk.sv
module iocs_decoder_chk #(
    parameter int DATA_W = 8,
    parameter int REG_AW = 2,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [REG_AW-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              io_valid,
    input logic              io_rd,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [2:0]        cs_code,
    input logic              xcvr_oe,
    input logic              rtc_ale,
    input logic              rtc_cs,
    input logic              cfg_page_cs,
    input logic              cfg_mem_cs
);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_valid && (io_rd ^ io_wr)) |->
            (cs_code == 3'd0 && !xcvr_oe && !rtc_ale && !rtc_cs
             && !cfg_page_cs && !cfg_mem_cs));

    assert_oe_tracks_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_oe == (cs_code != 3'd0));

    assert_rtc_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_cs |-> (rtc_ale && cs_code == 3'd2 && io_addr[ADDR_W-1:3] == '0 + 14));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rtc_cs, cfg_page_cs, cfg_mem_cs}));

    assert_page_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_page_cs |-> (io_wr && !io_rd && io_addr == ADDR_W'(16'h0C00)
                         && cs_code == 3'd6));

    assert_mem_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mem_cs |-> (io_addr[ADDR_W-1:8] == '0 + 8 && cs_code == 3'd6));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_AW'(1)) |=>
            (cfg_addr != REG_AW'(1) || cfg_rdata == $past(cfg_wdata)));

endmodule

bind iocs_decoder iocs_decoder_chk #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_iocs_decoder.sv
module test_iocs_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        io_valid = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
    logic [15:0] io_addr = '0;

    logic [7:0] rdata_w, rdata_n;
    logic [2:0] code_w, code_n;
    logic oe_w, ale_w, rcs_w, pg_w, mem_w;
    logic oe_n, ale_n, rcs_n, pg_n, mem_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iocs_decoder i_iocs_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_w), .io_valid(io_valid),
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .cs_code(code_w),
        .xcvr_oe(oe_w), .rtc_ale(ale_w), .rtc_cs(rcs_w),
        .cfg_page_cs(pg_w), .cfg_mem_cs(mem_w)
    );

    iocs_decoder #(.KBD_ALL_PORTS(1'b0)) i_iocs_decoder_narrow (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_n), .io_valid(io_valid),
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .cs_code(code_n),
        .xcvr_oe(oe_n), .rtc_ale(ale_n), .rtc_cs(rcs_n),
        .cfg_page_cs(pg_n), .cfg_mem_cs(mem_n)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  c0;
        logic [7:0]  c1;
        logic        v;
        logic        rd;
        logic        wr;
        logic [15:0] a;
        logic [2:0]  code;
        logic [3:0]  aux;   // {rtc_ale, rtc_cs, cfg_page_cs, cfg_mem_cs}
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0060, 3'd1, 4'b0000}, // R4
        '{4'd4,  8'h03, 8'h4C, 1'b1, 1'b0, 1'b1, 16'h0066, 3'd1, 4'b0000}, // R4
        '{4'd4,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0062, 3'd1, 4'b0000}, // R4
        '{4'd4,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0061, 3'd0, 4'b0000}, // R4
        '{4'd4,  8'h01, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0064, 3'd0, 4'b0000}, // R4
        '{4'd5,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0070, 3'd2, 4'b1100}, // R5
        '{4'd5,  8'h03, 8'h4C, 1'b1, 1'b0, 1'b1, 16'h0077, 3'd2, 4'b1100}, // R5
        '{4'd5,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0078, 3'd0, 4'b0000}, // R5
        '{4'd5,  8'h02, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0075, 3'd0, 4'b0000}, // R5
        '{4'd3,  8'h03, 8'h4C, 1'b0, 1'b1, 1'b0, 16'h0070, 3'd0, 4'b0000}, // R3
        '{4'd3,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b1, 16'h0070, 3'd0, 4'b0000}, // R3
        '{4'd3,  8'h03, 8'h4C, 1'b1, 1'b0, 1'b0, 16'h0060, 3'd0, 4'b0000}, // R3
        '{4'd6,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h03F8, 3'd3, 4'b0000}, // R6
        '{4'd6,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h02F8, 3'd0, 4'b0000}, // R6
        '{4'd6,  8'h03, 8'h4D, 1'b1, 1'b0, 1'b1, 16'h02FF, 3'd3, 4'b0000}, // R6
        '{4'd6,  8'h03, 8'h4E, 1'b1, 1'b1, 1'b0, 16'h03F8, 3'd0, 4'b0000}, // R6
        '{4'd6,  8'h03, 8'h4E, 1'b1, 1'b1, 1'b0, 16'h02F8, 3'd0, 4'b0000}, // R6
        '{4'd6,  8'h03, 8'h4F, 1'b1, 1'b1, 1'b0, 16'h03FF, 3'd0, 4'b0000}, // R6
        '{4'd7,  8'h03, 8'h41, 1'b1, 1'b1, 1'b0, 16'h03FC, 3'd4, 4'b0000}, // R7
        '{4'd7,  8'h03, 8'h41, 1'b1, 1'b1, 1'b0, 16'h02F8, 3'd3, 4'b0000}, // R7
        '{4'd7,  8'h03, 8'h45, 1'b1, 1'b1, 1'b0, 16'h02F8, 3'd3, 4'b0000}, // R7
        '{4'd7,  8'h03, 8'h40, 1'b1, 1'b0, 1'b1, 16'h03F8, 3'd3, 4'b0000}, // R7
        '{4'd7,  8'h03, 8'h47, 1'b1, 1'b1, 1'b0, 16'h02F8, 3'd4, 4'b0000}, // R7
        '{4'd7,  8'h03, 8'h4B, 1'b1, 1'b1, 1'b0, 16'h03F8, 3'd0, 4'b0000}, // R7
        '{4'd7,  8'h03, 8'h4B, 1'b1, 1'b1, 1'b0, 16'h02F8, 3'd0, 4'b0000}, // R7
        '{4'd8,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h03BC, 3'd5, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h4C, 1'b1, 1'b0, 1'b1, 16'h03BF, 3'd5, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h03BB, 3'd0, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h5C, 1'b1, 1'b1, 1'b0, 16'h0378, 3'd5, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h5C, 1'b1, 1'b1, 1'b0, 16'h037F, 3'd5, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h5C, 1'b1, 1'b1, 1'b0, 16'h03BC, 3'd0, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h6C, 1'b1, 1'b1, 1'b0, 16'h0278, 3'd5, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h7C, 1'b1, 1'b1, 1'b0, 16'h0278, 3'd0, 4'b0000}, // R8
        '{4'd8,  8'h03, 8'h7C, 1'b1, 1'b1, 1'b0, 16'h03BC, 3'd0, 4'b0000}, // R8
        '{4'd9,  8'h03, 8'hCC, 1'b1, 1'b0, 1'b1, 16'h0C00, 3'd6, 4'b0010}, // R9
        '{4'd9,  8'h03, 8'hCC, 1'b1, 1'b1, 1'b0, 16'h0C00, 3'd0, 4'b0000}, // R9
        '{4'd9,  8'h03, 8'h4C, 1'b1, 1'b0, 1'b1, 16'h0C00, 3'd0, 4'b0000}, // R9
        '{4'd10, 8'h03, 8'hCC, 1'b1, 1'b1, 1'b0, 16'h0880, 3'd6, 4'b0001}, // R10
        '{4'd10, 8'h03, 8'hCC, 1'b1, 1'b0, 1'b1, 16'h08FF, 3'd6, 4'b0001}, // R10
        '{4'd10, 8'h03, 8'hCC, 1'b1, 1'b1, 1'b0, 16'h0900, 3'd0, 4'b0000}, // R10
        '{4'd10, 8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0800, 3'd0, 4'b0000}, // R10
        '{4'd11, 8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0092, 3'd7, 4'b0000}, // R11
        '{4'd11, 8'h03, 8'h0C, 1'b1, 1'b0, 1'b1, 16'h0092, 3'd0, 4'b0000}, // R11
        '{4'd11, 8'h03, 8'h4C, 1'b1, 1'b1, 1'b0, 16'h0093, 3'd0, 4'b0000}  // R11
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] off, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = off;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] off, input logic [7:0] exp,
                            input string tag);
        cfg_addr = off;
        #1;
        check(tag, {24'h0, rdata_w}, {24'h0, exp});
    endtask

    task automatic io_drive(input logic v, input logic rd, input logic wr,
                            input logic [15:0] a);
        io_valid = v;
        io_rd = rd;
        io_wr = wr;
        io_addr = a;
        #1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and idle outputs
        reg_read(2'd0, 8'h03, "R1 control reset");
        reg_read(2'd1, 8'h4C, "R1 select reset");
        reg_read(2'd2, 8'h00, "R1 offset2 reads zero");
        reg_read(2'd3, 8'h00, "R1 offset3 reads zero");
        check("R3 idle code after reset", {29'h0, code_w}, 32'h0);

        // R4: keyboard variant parameter
        io_drive(1'b1, 1'b1, 1'b0, 16'h0062);
        check("R4 narrow 62h", {29'h0, code_n}, 32'd0);
        check("R4 wide 62h", {29'h0, code_w}, 32'd1);
        io_drive(1'b1, 1'b1, 1'b0, 16'h0064);
        check("R4 narrow 64h", {29'h0, code_n}, 32'd1);
        io_drive(1'b0, 1'b0, 1'b0, 16'h0000);

        // R2: write timing, reserved readback, unused offsets
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 2'd1;
        cfg_wdata = 8'hAA;
        #1;
        check("R2 old value before edge", {24'h0, rdata_w}, 32'h4C);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R2 new value after edge", {24'h0, rdata_w}, 32'hAA);
        reg_write(2'd2, 8'hFF);
        reg_write(2'd3, 8'h5A);
        reg_read(2'd2, 8'h00, "R2 offset2 ignored");
        reg_read(2'd3, 8'h00, "R2 offset3 ignored");
        reg_read(2'd0, 8'h03, "R2 control untouched");
        reg_read(2'd1, 8'hAA, "R2 select untouched");
        reg_write(2'd0, 8'hF1);
        reg_read(2'd0, 8'hF1, "R2 stored upper bits");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd0, VECS[i].c0);
            reg_write(2'd1, VECS[i].c1);
            io_drive(VECS[i].v, VECS[i].rd, VECS[i].wr, VECS[i].a);
            // R12: oe expected high exactly when code nonzero
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  {24'h0, code_w, ale_w, rcs_w, pg_w, mem_w, oe_w},
                  {24'h0, VECS[i].code, VECS[i].aux, (VECS[i].code != 3'd0)});
            io_drive(1'b0, 1'b0, 1'b0, 16'h0000);
        end

        // R12 corner: matching address but inactive cycle
        io_drive(1'b1, 1'b1, 1'b1, 16'h0092);
        check("R12 oe low when inactive", {31'h0, oe_w}, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule